// File: doc/BRIEF.md
# Sign-Magnitude Unsigned Subtractor

This combinational block subtracts an unsigned subtrahend from an unsigned minuend of the same width, together with an incoming borrow. It returns the distance between the two operands as an unsigned magnitude, plus a flag that marks a negative result. The difference comes from a chain of one-bit borrow cells, one per bit, with each borrow passed from the least significant bit up to the most significant bit.

When no borrow leaves the top cell, the minuend was at least as large as the subtrahend plus borrow-in, and the raw difference goes out unchanged. When a borrow does leave the top cell, the raw difference has wrapped to 2^n + M − N − Bin. A correction stage then takes the two's complement of the raw value, which gives N + Bin − M, and raises the negative flag. Callers doing a stand-alone subtract tie the borrow input low. A wider subtract can feed in the borrow of a lower slice.

Top module: `signmag_subtractor`

## Requirements
- R1: Each bit cell produces difference m^s^b and borrow-out (~m&s)|(~(m^s)&b). As a result, bit 0 of the magnitude always equals minuend[0]^subtrahend[0]^borrow_in.
- R2: borrow_out is 1 exactly when minuend < subtrahend + borrow_in, with the comparison done in full precision.
- R3: When borrow_out is 0, magnitude equals minuend − subtrahend − borrow_in and negative is 0.
- R4: When borrow_out is 1, magnitude equals (subtrahend + borrow_in − minuend) mod 2^WIDTH, which is the two's complement of the raw difference, and negative is 1. The only case that wraps is minuend = 0, subtrahend = 2^WIDTH − 1, borrow_in = 1, which yields magnitude 0 with negative = 1.
- R5: When minuend equals subtrahend and borrow_in is 0, magnitude is 0 and negative is 0.
- R6: negative always equals borrow_out.
- R7: With borrow_in tied to 0, magnitude equals |minuend − subtrahend| for every operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| minuend | input | WIDTH | Unsigned value subtracted from |
| subtrahend | input | WIDTH | Unsigned value subtracted |
| borrow_in | input | 1 | Borrow into bit 0; 0 for a stand-alone subtract |
| magnitude | output | WIDTH | Unsigned distance between the operands |
| negative | output | 1 | Set when subtrahend + borrow_in exceeds minuend |
| borrow_out | output | 1 | Borrow leaving the most significant cell |

## Verification
The bench sweeps every 6-bit operand pair under both borrow-in values, so it covers the equal-operand case, the off-by-one pairs and the single wrapping case. A correction stage that only inverted the raw bits, without the increment, would leave every negative magnitude short by one. A borrow cell with the wrong borrow term would show up as a wrong borrow_out on pairs that differ by one bit. Checking bit 0 of the magnitude on its own catches a cell whose difference term is wrong, even when the correction would hide it elsewhere. Driving borrow_in = 1 with equal operands catches a chain whose bottom input is ignored, because that result must come out negative with magnitude 1.

// File: rtl/signmag_sub_pkg.sv
package signmag_sub_pkg;

  // Difference bit of a one-bit subtract.
  function automatic logic cell_diff(input logic m, input logic s, input logic b);
    return m ^ s ^ b;
  endfunction

  // Borrow leaving a one-bit subtract.
  function automatic logic cell_borrow(input logic m, input logic s, input logic b);
    return (~m & s) | (~(m ^ s) & b);
  endfunction

endpackage

// File: rtl/borrow_cell.sv
module borrow_cell
  import signmag_sub_pkg::*;
(
  input  logic m_bit,
  input  logic s_bit,
  input  logic b_in,
  output logic d_bit,
  output logic b_out
);

  assign d_bit = cell_diff(m_bit, s_bit, b_in);
  assign b_out = cell_borrow(m_bit, s_bit, b_in);

  // Arithmetic balance: m - s - b == d - 2*bout, rearranged to be unsigned.
  logic [1:0] lhs_sum;
  logic [1:0] rhs_sum;
  always_comb begin
    lhs_sum = {1'b0, m_bit} + {b_out, 1'b0};
    rhs_sum = {1'b0, s_bit} + {1'b0, b_in} + {1'b0, d_bit};
    AST_CELL_BALANCE: assert (lhs_sum == rhs_sum) else $error("cell balance broken"); // R1
  end

endmodule

// File: rtl/borrow_chain.sv
module borrow_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] m_i,
  input  logic [WIDTH-1:0] s_i,
  input  logic             b_i,
  output logic [WIDTH-1:0] raw_o,
  output logic             b_o
);

  logic [WIDTH:0] brw;
  assign brw[0] = b_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    borrow_cell u_cell (
      .m_bit (m_i[i]),
      .s_bit (s_i[i]),
      .b_in  (brw[i]),
      .d_bit (raw_o[i]),
      .b_out (brw[i+1])
    );
  end

  assign b_o = brw[WIDTH];

  always_comb begin
    if (m_i == s_i && !b_i) begin
      AST_CHAIN_ZERO: assert (!b_o && raw_o == '0) else $error("equal operands not zero"); // R5
    end
  end

endmodule

// File: rtl/magnitude_fix.sv
module magnitude_fix #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] raw_i,
  input  logic             wrap_i,
  output logic [WIDTH-1:0] mag_o,
  output logic             neg_o
);

  function automatic logic [WIDTH-1:0] negate(input logic [WIDTH-1:0] v);
    return ~v + WIDTH'(1);
  endfunction

  logic [WIDTH-1:0] negated;
  assign negated = negate(raw_i);
  assign mag_o   = wrap_i ? negated : raw_i;
  assign neg_o   = wrap_i;

  logic [WIDTH-1:0] cancel_sum;
  always_comb begin
    cancel_sum = raw_i + mag_o;
    if (wrap_i) begin
      AST_FIX_CANCEL: assert (cancel_sum == '0) else $error("correction not a complement"); // R4
    end
  end

endmodule

// File: rtl/signmag_subtractor.sv
module signmag_subtractor #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] minuend,
  input  logic [WIDTH-1:0] subtrahend,
  input  logic             borrow_in,
  output logic [WIDTH-1:0] magnitude,
  output logic             negative,
  output logic             borrow_out
);

  localparam int WIDE = WIDTH + 1;

  logic [WIDTH-1:0] raw_diff;
  logic             chain_borrow;

  borrow_chain #(.WIDTH(WIDTH)) u_chain (
    .m_i   (minuend),
    .s_i   (subtrahend),
    .b_i   (borrow_in),
    .raw_o (raw_diff),
    .b_o   (chain_borrow)
  );

  magnitude_fix #(.WIDTH(WIDTH)) u_fix (
    .raw_i  (raw_diff),
    .wrap_i (chain_borrow),
    .mag_o  (magnitude),
    .neg_o  (negative)
  );

  assign borrow_out = chain_borrow;

  logic [WIDE-1:0] take_wide;
  logic [WIDE-1:0] rebuilt_wide;
  always_comb begin
    take_wide    = WIDE'(subtrahend) + WIDE'(borrow_in);
    rebuilt_wide = WIDE'(magnitude) + take_wide;
    AST_BORROW_ORDER: assert (borrow_out == (WIDE'(minuend) < take_wide)) else $error("borrow order"); // R2
    AST_SIGN_IS_BORROW: assert (negative == borrow_out) else $error("sign mismatch"); // R6
    if (!borrow_out) begin
      AST_NO_BORROW_DIFF: assert (rebuilt_wide == WIDE'(minuend)) else $error("plain difference"); // R3
    end
  end

endmodule

// File: tb/signmag_subtractor_test.sv
module signmag_subtractor_test;

  localparam int W = 6;
  localparam int SPAN = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] m_drv = '0;
  logic [W-1:0] s_drv = '0;
  logic b_drv = 1'b0;
  logic [W-1:0] mag;
  logic neg;
  logic bout;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  signmag_subtractor #(.WIDTH(W)) uut (
    .minuend    (m_drv),
    .subtrahend (s_drv),
    .borrow_in  (b_drv),
    .magnitude  (mag),
    .negative   (neg),
    .borrow_out (bout)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s m=%0d s=%0d b=%0d actual=%0d expected=%0d",
               req, m_drv, s_drv, b_drv, act, exp);
    end
  endtask

  task automatic run_vec(input int m, input int s, input int b);
    int want_b;
    int want_mag;
    @(negedge clk);
    m_drv = W'(m);
    s_drv = W'(s);
    b_drv = b[0];
    @(posedge clk);
    #5;
    want_b = (m < s + b) ? 1 : 0;
    want_mag = want_b ? ((s + b - m) % SPAN) : (m - s - b);
    check("R2", int'(bout), want_b);
    check("R6", int'(neg), int'(bout));
    check("R1", int'(mag[0]), (m ^ s ^ b) & 1);
    if (m == s && b == 0)
      check("R5", int'(mag) + 2 * int'(neg), 0);
    else if (want_b != 0)
      check(b == 0 ? "R4/R7" : "R4", int'(mag), want_mag);
    else
      check(b == 0 ? "R3/R7" : "R3", int'(mag), want_mag);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    #5;
    // Idle inputs after reset: zero result, positive.
    check("R5", int'(mag), 0);
    check("R6", int'(neg), 0);
    // Named corners first.
    run_vec(0, SPAN - 1, 1); // R4 wrapping case
    run_vec(5, 5, 1);        // R4 equal operands with borrow-in
    for (int b = 0; b < 2; b++)
      for (int m = 0; m < SPAN; m++)
        for (int s = 0; s < SPAN; s++)
          run_vec(m, s, b);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule